// File: doc/BRIEF.md
# Decode-stage branch resolver

This block decides conditional branches while the branch is still in the decode stage of an in-order five-stage pipeline. A comparator of its own, separate from the execute ALU, checks whether the two source operands are equal or unequal. An adder of its own forms the branch destination from the incremented program counter and the immediate offset. Because the decision is ready at the end of decode rather than in the memory stage, a taken branch costs one fetch slot instead of three.

Each compared operand comes from one of three places. The default is the register file read data. The second is the ALU result held in the EX/MEM pipeline register. The third is the write-back value held in the MEM/WB register. A producer that is still too young to supply its value raises a stall request. Two cases cause this: any writing instruction in execute, and a load in the memory stage. Together these give one stall cycle behind an ALU producer and two behind a load. The fetch unit uses the taken flag and the target to redirect and flush, and the pipeline control uses the stall flag to hold decode.

Top module: `brid_resolve`

## Requirements
- R1: `br_target` always equals `id_pc_next` plus the sign-extended 16-bit `id_offset` shifted left by 2, truncated to 32 bits. Bit 15 of the offset is the sign.
- R2: For an active branch with no stall, `br_taken` is 1 in two cases: `id_br_kind` = 1 (branch if equal) and the two selected operands are equal, or `id_br_kind` = 2 (branch if not equal) and they differ. Otherwise `br_taken` is 0.
- R3: When `id_valid` is 0, or when `id_br_kind` is 0 or 3 (not a branch), `br_taken` and `br_stall` are both 0, whatever hazards are present.
- R4: An active branch raises `br_stall` when `ex_wr` is 1 and a nonzero `ex_rd` equals `id_rs` or `id_rt`.
- R5: An active branch raises `br_stall` when `mem_wr` and `mem_load` are both 1 and a nonzero `mem_rd` equals `id_rs` or `id_rt`. A load directly ahead therefore stalls two cycles, and a load two ahead stalls one.
- R6: When `mem_wr` is 1, `mem_load` is 0 and a nonzero `mem_rd` matches a compared register, that operand is taken from `mem_alu` and no stall is raised.
- R7: When `wb_wr` is 1 and a nonzero `wb_rd` matches a compared register, the operand is taken from `wb_data`. A matching non-load EX/MEM entry takes priority over a matching MEM/WB entry.
- R8: Register index 0 never forwards and never stalls. Its operand is always the register file data.
- R9: While `br_stall` is 1, `br_taken` is 0.
- R10: While `rst` is 1, `br_taken` and `br_stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; holds the decision outputs low |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_br_kind | input | 2 | 0 none, 1 branch if equal, 2 branch if not equal, 3 none |
| id_pc_next | input | 32 | Incremented program counter of the decode instruction |
| id_offset | input | 16 | Signed word offset of the branch |
| id_rs | input | 5 | First compared register index |
| id_rt | input | 5 | Second compared register index |
| rf_rs_data | input | 32 | Register file data for id_rs |
| rf_rt_data | input | 32 | Register file data for id_rt |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | 5 | Execute-stage destination index |
| mem_wr | input | 1 | EX/MEM instruction writes a register |
| mem_load | input | 1 | EX/MEM instruction is a load |
| mem_rd | input | 5 | EX/MEM destination index |
| mem_alu | input | 32 | EX/MEM ALU result |
| wb_wr | input | 1 | MEM/WB instruction writes a register |
| wb_rd | input | 5 | MEM/WB destination index |
| wb_data | input | 32 | MEM/WB write-back value |
| br_taken | output | 1 | Branch is resolved taken this cycle |
| br_target | output | 32 | Branch destination address |
| br_stall | output | 1 | Hold decode: a compared value is not ready |

## Verification
The bench builds the block with its default sizes: a 32-bit data path, 5-bit register indices, a 16-bit offset and a shift of 2. With these sizes the sign bit of the offset sits at bit 15. This puts backward branches within reach, and also a target that wraps past the top of the address space. The same sizes make register 0 and register 31 the edge indices for the hazard match and the forwarding match. The bench drives the pipeline-stage slots one decode cycle at a time to reproduce a load or ALU producer at each distance from the branch. Each cycle checks the stall, the forwarded operand and the priority between sources.

// File: rtl/brid_pkg.sv
package brid_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_EQ   = 2'd1,
    BR_NE   = 2'd2,
    BR_RSVD = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/brid_target.sv
module brid_target #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int SHIFT = 2
) (
  input  logic [XLEN-1:0]  pc_next,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target
);
  localparam int EXT_W = XLEN - OFF_W;

  logic [XLEN-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    target  = pc_next + (off_ext << SHIFT);
  end
endmodule

// File: rtl/brid_fwd_mux.sv
module brid_fwd_mux
  import brid_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic [RAW-1:0]  src_reg,
  input  logic [XLEN-1:0] rf_data,
  input  logic            mem_wr,
  input  logic            mem_load,
  input  logic [RAW-1:0]  mem_rd,
  input  logic [XLEN-1:0] mem_alu,
  input  logic            wb_wr,
  input  logic [RAW-1:0]  wb_rd,
  input  logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] operand
);
  fwd_src_e sel;
  logic     nz;

  // Newest ready producer wins; a load in EX/MEM has no value yet.
  always_comb begin
    nz = (src_reg != '0);
    if (nz && mem_wr && !mem_load && (mem_rd == src_reg))
      sel = SRC_EXMEM;
    else if (nz && wb_wr && (wb_rd == src_reg))
      sel = SRC_MEMWB;
    else
      sel = SRC_RF;
  end

  always_comb begin
    unique case (sel)
      SRC_EXMEM: operand = mem_alu;
      SRC_MEMWB: operand = wb_data;
      default:   operand = rf_data;
    endcase
  end
endmodule

// File: rtl/brid_hazard.sv
module brid_hazard #(
  parameter int RAW = 5
) (
  input  logic           br_active,
  input  logic [RAW-1:0] rs,
  input  logic [RAW-1:0] rt,
  input  logic           ex_wr,
  input  logic [RAW-1:0] ex_rd,
  input  logic           mem_wr,
  input  logic           mem_load,
  input  logic [RAW-1:0] mem_rd,
  output logic           stall
);
  logic ex_hit;
  logic mem_hit;

  function automatic logic reg_hit(input logic [RAW-1:0] dst,
                                   input logic [RAW-1:0] a,
                                   input logic [RAW-1:0] b);
    return (dst != '0) && ((dst == a) || (dst == b));
  endfunction

  always_comb begin
    ex_hit  = ex_wr && reg_hit(ex_rd, rs, rt);
    mem_hit = mem_wr && mem_load && reg_hit(mem_rd, rs, rt);
    stall   = br_active && (ex_hit || mem_hit);
  end
endmodule

// File: rtl/brid_resolve.sv
module brid_resolve
  import brid_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RAW   = 5,
  parameter int OFF_W = 16,
  parameter int SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic [1:0]       id_br_kind,
  input  logic [XLEN-1:0]  id_pc_next,
  input  logic [OFF_W-1:0] id_offset,
  input  logic [RAW-1:0]   id_rs,
  input  logic [RAW-1:0]   id_rt,
  input  logic [XLEN-1:0]  rf_rs_data,
  input  logic [XLEN-1:0]  rf_rt_data,
  input  logic             ex_wr,
  input  logic [RAW-1:0]   ex_rd,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic [RAW-1:0]   mem_rd,
  input  logic [XLEN-1:0]  mem_alu,
  input  logic             wb_wr,
  input  logic [RAW-1:0]   wb_rd,
  input  logic [XLEN-1:0]  wb_data,
  output logic             br_taken,
  output logic [XLEN-1:0]  br_target,
  output logic             br_stall
);
  localparam int NOPS = 2;

  br_kind_e        kind;
  logic            is_br;
  logic            active;
  logic            haz_stall;
  logic            ops_equal;
  logic [RAW-1:0]  src_idx [NOPS];
  logic [XLEN-1:0] src_rf  [NOPS];
  logic [XLEN-1:0] opnd    [NOPS];

  always_comb begin
    kind       = br_kind_e'(id_br_kind);
    is_br      = (kind == BR_EQ) || (kind == BR_NE);
    active     = !rst && id_valid && is_br;
    src_idx[0] = id_rs;
    src_idx[1] = id_rt;
    src_rf[0]  = rf_rs_data;
    src_rf[1]  = rf_rt_data;
  end

  brid_target #(.XLEN(XLEN), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_target (
    .pc_next (id_pc_next),
    .offset  (id_offset),
    .target  (br_target)
  );

  genvar g;
  generate
    for (g = 0; g < NOPS; g++) begin : g_op
      brid_fwd_mux #(.XLEN(XLEN), .RAW(RAW)) u_mux (
        .src_reg  (src_idx[g]),
        .rf_data  (src_rf[g]),
        .mem_wr   (mem_wr),
        .mem_load (mem_load),
        .mem_rd   (mem_rd),
        .mem_alu  (mem_alu),
        .wb_wr    (wb_wr),
        .wb_rd    (wb_rd),
        .wb_data  (wb_data),
        .operand  (opnd[g])
      );
    end
  endgenerate

  brid_hazard #(.RAW(RAW)) u_hazard (
    .br_active (active),
    .rs        (id_rs),
    .rt        (id_rt),
    .ex_wr     (ex_wr),
    .ex_rd     (ex_rd),
    .mem_wr    (mem_wr),
    .mem_load  (mem_load),
    .mem_rd    (mem_rd),
    .stall     (haz_stall)
  );

  always_comb begin
    ops_equal = (opnd[0] == opnd[1]);
    br_stall  = haz_stall;
    br_taken  = active && !haz_stall &&
                (((kind == BR_EQ) && ops_equal) || ((kind == BR_NE) && !ops_equal));
  end

  // R9: a stalled branch never redirects fetch
  a_r9_taken_not_stalled: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> !br_stall);

  // R3: no stall request without a valid branch in decode
  a_r3_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
    (!id_valid || !is_br) |-> (!br_stall && !br_taken));

  // R5: a load in EX/MEM feeding a compared register holds the branch
  a_r5_load_mem_stall: assert property (@(posedge clk) disable iff (rst)
    (id_valid && is_br && mem_wr && mem_load && (mem_rd != '0) &&
     ((mem_rd == id_rs) || (mem_rd == id_rt))) |-> br_stall);

  // R8: register 0 always compares the register file value
  a_r8_zero_from_rf: assert property (@(posedge clk) disable iff (rst)
    (id_rs == '0) |-> (opnd[0] == rf_rs_data));

  // R4: any writer in execute feeding a compared register holds the branch
  a_r4_ex_stall: assert property (@(posedge clk) disable iff (rst)
    (id_valid && is_br && ex_wr && (ex_rd != '0) &&
     ((ex_rd == id_rs) || (ex_rd == id_rt))) |-> br_stall);
endmodule

// File: tb/brid_resolve_tb.sv
`timescale 1ns/1ps
module brid_resolve_tb;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  typedef struct {
    string       tag;
    logic        taken;
    logic        stall;
    logic [31:0] target;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, id_valid, ex_wr, mem_wr, mem_load, wb_wr;
  logic [1:0]  id_br_kind;
  logic [31:0] id_pc_next, rf_rs_data, rf_rt_data, mem_alu, wb_data;
  logic [15:0] id_offset;
  logic [4:0]  id_rs, id_rt, ex_rd, mem_rd, wb_rd;
  logic        br_taken, br_stall;
  logic [31:0] br_target;

  // staged stimulus
  logic        s_rst, s_valid, s_ex_wr, s_mem_wr, s_mem_load, s_wb_wr;
  logic [1:0]  s_kind;
  logic [31:0] s_pc, s_rsd, s_rtd, s_mem_alu, s_wb_data;
  logic [15:0] s_off;
  logic [4:0]  s_rs, s_rt, s_ex_rd, s_mem_rd, s_wb_rd;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  brid_resolve u_dut (
    .clk, .rst, .id_valid, .id_br_kind, .id_pc_next, .id_offset,
    .id_rs, .id_rt, .rf_rs_data, .rf_rt_data, .ex_wr, .ex_rd,
    .mem_wr, .mem_load, .mem_rd, .mem_alu, .wb_wr, .wb_rd, .wb_data,
    .br_taken, .br_target, .br_stall
  );

  task automatic clear();
    s_rst = 0; s_valid = 1; s_kind = 2'd1; s_pc = 32'h0000_1000; s_off = 16'd4;
    s_rs = 5'd1; s_rt = 5'd2; s_rsd = 32'd5; s_rtd = 32'd5;
    s_ex_wr = 0; s_ex_rd = 5'd0; s_mem_wr = 0; s_mem_load = 0; s_mem_rd = 5'd0;
    s_mem_alu = 32'd0; s_wb_wr = 0; s_wb_rd = 5'd0; s_wb_data = 32'd0;
  endtask

  function automatic logic [31:0] pick(input logic [4:0] r, input logic [31:0] rf);
    if (r == 0) return rf;
    if (s_mem_wr && !s_mem_load && s_mem_rd == r) return s_mem_alu;
    if (s_wb_wr && s_wb_rd == r) return s_wb_data;
    return rf;
  endfunction

  task automatic send(input string tag);
    exp_t e;
    logic act, st, hx, hm;
    logic [31:0] a, b;
    @(negedge clk);
    rst = s_rst; id_valid = s_valid; id_br_kind = s_kind; id_pc_next = s_pc;
    id_offset = s_off; id_rs = s_rs; id_rt = s_rt; rf_rs_data = s_rsd; rf_rt_data = s_rtd;
    ex_wr = s_ex_wr; ex_rd = s_ex_rd; mem_wr = s_mem_wr; mem_load = s_mem_load;
    mem_rd = s_mem_rd; mem_alu = s_mem_alu; wb_wr = s_wb_wr; wb_rd = s_wb_rd;
    wb_data = s_wb_data;
    act = !s_rst && s_valid && (s_kind == 2'd1 || s_kind == 2'd2);
    hx  = s_ex_wr && s_ex_rd != 0 && (s_ex_rd == s_rs || s_ex_rd == s_rt);
    hm  = s_mem_wr && s_mem_load && s_mem_rd != 0 && (s_mem_rd == s_rs || s_mem_rd == s_rt);
    st  = act && (hx || hm);
    a = pick(s_rs, s_rsd);
    b = pick(s_rt, s_rtd);
    e.tag    = tag;
    e.stall  = st;
    e.taken  = act && !st && ((s_kind == 2'd1 && a == b) || (s_kind == 2'd2 && a != b));
    e.target = s_pc + {{14{s_off[15]}}, s_off, 2'b00};
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks += 3;
      if (br_taken !== e.taken) begin
        failures++; $display("FAIL %s br_taken actual=%0b expected=%0b", e.tag, br_taken, e.taken);
      end
      if (br_stall !== e.stall) begin
        failures++; $display("FAIL %s br_stall actual=%0b expected=%0b", e.tag, br_stall, e.stall);
      end
      if (br_target !== e.target) begin
        failures++; $display("FAIL %s br_target actual=%h expected=%h", e.tag, br_target, e.target);
      end
    end
  end

  initial begin
    clear(); s_rst = 1;
    send("R10 reset holds outputs low");
    send("R10 reset second cycle");
    clear(); send("R2 beq equal taken");
    clear(); s_rtd = 32'd6; send("R2 beq unequal not taken");
    clear(); s_kind = 2'd2; s_rtd = 32'd6; send("R2 bne unequal taken");
    clear(); s_kind = 2'd2; send("R2 bne equal not taken");
    clear(); s_off = 16'hFFFF; send("R1 backward offset");
    clear(); s_pc = 32'hFFFF_FFF0; s_off = 16'h0010; send("R1 wrapping target");
    clear(); s_off = 16'h7FFF; send("R1 largest forward offset");
    clear(); s_kind = 2'd0; s_ex_wr = 1; s_ex_rd = 5'd1; send("R3 kind none ignores hazard");
    clear(); s_kind = 2'd3; s_ex_wr = 1; s_ex_rd = 5'd2; send("R3 kind reserved");
    clear(); s_valid = 0; s_mem_wr = 1; s_mem_load = 1; s_mem_rd = 5'd1; send("R3 invalid slot");
    clear(); s_ex_wr = 1; s_ex_rd = 5'd1; send("R4 ALU in EX matches rs");
    clear(); s_ex_wr = 1; s_ex_rd = 5'd2; s_rs = 5'd31; s_rt = 5'd2; send("R4 ALU in EX matches rt");
    clear(); s_ex_wr = 1; s_ex_rd = 5'd7; send("R4 EX writer other register");
    // load directly ahead: in EX, then in MEM, then forwarded from WB
    clear(); s_ex_wr = 1; s_ex_rd = 5'd1; send("R5 load in EX");
    clear(); s_mem_wr = 1; s_mem_load = 1; s_mem_rd = 5'd1; send("R5 load in MEM stalls");
    clear(); s_wb_wr = 1; s_wb_rd = 5'd1; s_wb_data = 32'd9; s_rtd = 32'd9;
    send("R7 load value from WB");
    clear(); s_mem_wr = 1; s_mem_load = 1; s_mem_rd = 5'd2; s_rs = 5'd3; send("R5 load in MEM on rt");
    clear(); s_mem_wr = 1; s_mem_rd = 5'd1; s_mem_alu = 32'hABCD; s_rsd = 32'd0; s_rtd = 32'hABCD;
    send("R6 EX/MEM ALU forward equal");
    clear(); s_kind = 2'd2; s_mem_wr = 1; s_mem_rd = 5'd2; s_mem_alu = 32'd5;
    s_rtd = 32'd77; send("R6 EX/MEM forward on rt bne");
    clear(); s_mem_wr = 1; s_mem_rd = 5'd1; s_mem_alu = 32'd11;
    s_wb_wr = 1; s_wb_rd = 5'd1; s_wb_data = 32'd5; s_rtd = 32'd11;
    send("R7 EX/MEM priority over MEM/WB");
    clear(); s_wb_wr = 1; s_wb_rd = 5'd2; s_wb_data = 32'd1; send("R7 WB forward makes unequal");
    clear(); s_rs = 5'd0; s_rt = 5'd0; s_rsd = 32'd0; s_rtd = 32'd0; s_ex_wr = 1; s_ex_rd = 5'd0;
    send("R8 register zero no stall");
    clear(); s_rs = 5'd0; s_rsd = 32'd0; s_rtd = 32'd0; s_mem_wr = 1; s_mem_rd = 5'd0;
    s_mem_alu = 32'd3; s_wb_wr = 1; s_wb_rd = 5'd0; s_wb_data = 32'd4; s_rt = 5'd4;
    send("R8 register zero no forward");
    clear(); s_ex_wr = 1; s_ex_rd = 5'd2; s_rsd = 32'd8; s_rtd = 32'd8; send("R9 stalled equal not taken");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule